// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides when a 32-bit RISC core enters an exception and performs the architectural state changes of that entry in a single clock edge. The pipeline presents synchronous requests: data storage fault, instruction storage fault, program trap and system call. Three asynchronous sources feed sticky pending bits: external interrupt, decrementer and system-management interrupt. The block owns the machine state register (MSR) and the two save/restore registers.

On entry it saves a return address and a masked copy of the MSR, then rewrites the MSR to clear the privileged-state bits. It copies the interrupt-endian bit into the little-endian bit. It issues a one-cycle redirect with a vector address made from a base, chosen by the IP bit, and a fixed offset per cause. The pipeline loads the MSR through a simple write port. An unknown synchronous code locks the block in a fatal state until reset.

Top module: `trap_entry_top`

## Requirements
- R1: After reset: redirect PC 0xFFF00100, MSR 0x00000040, both save registers 0, redirect strobe 0, fatal 0, and no asynchronous request pending.
- R2: On entry the second save register holds the old MSR ANDed with 0x0000FF73. For a program trap it also has bit 17 (0x00020000) set.
- R3: On entry the first save register holds nextPc for every cause except program trap. For a program trap it holds curPc.
- R4: On entry the MSR bits at mask 0x0004EF32 are cleared: POW 18, EE 15, PR 14, FP 13, FE0 11, SE 10, BE 9, FE1 8, IR 5, DR 4, RI 1. Every other bit is kept. With no entry in a cycle, msrWrEn=1 loads msrWrData into the MSR.
- R5: On entry the new MSR bit 0 (LE) equals the old bit 16 (ILE).
- R6: The redirect PC is the base ORed with a cause offset. The base is 0xFFF00000 when MSR bit 6 (IP) is 1, else 0. Offsets: data storage 0x300, instruction storage 0x400, external 0x500, program 0x700, decrementer 0x900, system call 0xC00, system management 0x1400.
- R7: Asynchronous requests are latched as sticky pending bits. One is taken only while MSR bit 15 (EE) is 1. It is taken in the cycle after its pending bit is set, at the earliest.
- R8: Among pending asynchronous requests, external wins over decrementer, which wins over system management. Taking one clears only its own pending bit.
- R9: syncCause codes are 0 data storage, 1 instruction storage, 2 program trap and 3 system call. They are taken regardless of EE. A synchronous request wins over pending asynchronous ones in the same cycle, and those stay pending.
- R10: syncValid with a syncCause of 4 to 7 sets a sticky fatal flag. While it is set, no entry of any kind occurs, until reset.
- R11: redirectValid is high for exactly the cycle after each entry decision. The PC, MSR and save registers change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncValid | input | 1 | Synchronous exception request |
| syncCause | input | 3 | Synchronous cause code |
| extIrq | input | 1 | External interrupt request |
| decEvent | input | 1 | Decrementer expiry request |
| smiReq | input | 1 | System-management interrupt request |
| curPc | input | 32 | Address of the current instruction |
| nextPc | input | 32 | Address of the next instruction |
| msrWrEn | input | 1 | MSR load enable |
| msrWrData | input | 32 | MSR load value |
| msrOut | output | 32 | Current MSR |
| srr0Out | output | 32 | Saved return address |
| srr1Out | output | 32 | Saved machine state |
| redirectPc | output | 32 | Vector or reset fetch address |
| redirectValid | output | 1 | Redirect strobe |
| fatal | output | 1 | Sticky fatal flag |

## Verification
The synchronous causes are each driven with MSR values that vary IP, ILE, LE and EE. These separate the vector base choice, the endian copy, the clear mask and the trap flag in the saved state. The curPc and nextPc values differ in every vector, so the saved return address shows which one was taken. Asynchronous sources are raised together and while EE is low. This shows the priority order, the EE gate and that only the taken bit clears. A synchronous request placed in the same cycle as an eligible asynchronous one shows the precedence. An unknown code followed by valid requests shows the fatal lock.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int XLEN = 32;
  localparam int NUM_ASYNC = 3;
  localparam int CAUSE_W = 3;
  localparam int OFF_W = 13;

  localparam int BIT_LE  = 0;
  localparam int BIT_IP  = 6;
  localparam int BIT_EE  = 15;
  localparam int BIT_ILE = 16;

  localparam logic [XLEN-1:0] MSR_CLEAR_MASK = 32'h0004_EF32;
  localparam logic [XLEN-1:0] MSR_SAVE_MASK  = 32'h0000_FF73;
  localparam logic [XLEN-1:0] PROG_FLAG      = 32'h0002_0000;

  localparam logic [CAUSE_W-1:0] C_DSTORE = 3'd0;
  localparam logic [CAUSE_W-1:0] C_ISTORE = 3'd1;
  localparam logic [CAUSE_W-1:0] C_PROG   = 3'd2;
  localparam logic [CAUSE_W-1:0] C_SCALL  = 3'd3;

  typedef struct packed {
    logic             take;
    logic             useCur;
    logic             progFlag;
    logic [OFF_W-1:0] vecOff;
  } entryStrobe_t;

  function automatic logic [OFF_W-1:0] syncOffset(input logic [CAUSE_W-1:0] c);
    case (c)
      C_DSTORE: syncOffset = 13'h0300;
      C_ISTORE: syncOffset = 13'h0400;
      C_PROG:   syncOffset = 13'h0700;
      default:  syncOffset = 13'h0C00;
    endcase
  endfunction

  // index 0 external, 1 decrementer, 2 system management
  function automatic logic [OFF_W-1:0] asyncOffset(input int idx);
    case (idx)
      0:       asyncOffset = 13'h0500;
      1:       asyncOffset = 13'h0900;
      default: asyncOffset = 13'h1400;
    endcase
  endfunction
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 syncValid,
  input  logic [CAUSE_W-1:0]   syncCause,
  input  logic [NUM_ASYNC-1:0] asyncReq,
  input  logic                 msrEe,
  output entryStrobe_t         strobe,
  output logic                 fatal
);
  localparam logic [CAUSE_W-1:0] LAST_CODE = C_SCALL;

  logic [NUM_ASYNC-1:0] pendQ;
  logic [NUM_ASYNC-1:0] clrPend;
  logic                 fatalQ;
  logic                 setFatal;

  always_comb begin
    strobe   = '0;
    clrPend  = '0;
    setFatal = 1'b0;
    if (!fatalQ) begin
      if (syncValid) begin
        if (syncCause <= LAST_CODE) begin
          strobe.take     = 1'b1;
          strobe.useCur   = (syncCause == C_PROG);
          strobe.progFlag = (syncCause == C_PROG);
          strobe.vecOff   = syncOffset(syncCause);
        end else begin
          setFatal = 1'b1;
        end
      end else if (msrEe) begin
        // descending walk: lowest index is assigned last and wins
        for (int i = NUM_ASYNC - 1; i >= 0; i--) begin
          if (pendQ[i]) begin
            strobe.take   = 1'b1;
            strobe.useCur = 1'b0;
            strobe.vecOff = asyncOffset(i);
            clrPend       = '0;
            clrPend[i]    = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      fatalQ <= 1'b0;
    end else begin
      pendQ  <= (pendQ & ~clrPend) | asyncReq;
      fatalQ <= fatalQ | setFatal;
    end
  end

  assign fatal = fatalQ;

  assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    fatalQ |=> fatalQ);
  assert_fatal_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    fatalQ |-> !strobe.take);
  assert_async_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !syncValid) |-> msrEe);
  assert_clear_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrPend));
  assert_sync_keeps_pend_R9: assert property (@(posedge clk) disable iff (!rstN)
    syncValid |-> (clrPend == '0));
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC  = 32'hFFF0_0100,
  parameter logic [XLEN-1:0] RESET_MSR = 32'h0000_0040,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFF0_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  entryStrobe_t    strobe,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic            msrWrEn,
  input  logic [XLEN-1:0] msrWrData,
  output logic [XLEN-1:0] msrOut,
  output logic [XLEN-1:0] srr0Out,
  output logic [XLEN-1:0] srr1Out,
  output logic [XLEN-1:0] redirectPc,
  output logic            redirectValid
);
  logic [XLEN-1:0] msrQ, srr0Q, srr1Q, pcQ;
  logic            redirQ;
  logic [XLEN-1:0] entryMsr, vecBase, vecAddr, savedMsr;

  always_comb begin
    entryMsr         = msrQ & ~MSR_CLEAR_MASK;
    entryMsr[BIT_LE] = msrQ[BIT_ILE];
    vecBase          = entryMsr[BIT_IP] ? HIGH_BASE : '0;
    vecAddr          = vecBase | {{(XLEN-OFF_W){1'b0}}, strobe.vecOff};
    savedMsr         = (msrQ & MSR_SAVE_MASK) | (strobe.progFlag ? PROG_FLAG : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msrQ   <= RESET_MSR;
      srr0Q  <= '0;
      srr1Q  <= '0;
      pcQ    <= RESET_PC;
      redirQ <= 1'b0;
    end else begin
      redirQ <= strobe.take;
      if (strobe.take) begin
        msrQ  <= entryMsr;
        srr0Q <= strobe.useCur ? curPc : nextPc;
        srr1Q <= savedMsr;
        pcQ   <= vecAddr;
      end else if (msrWrEn) begin
        msrQ <= msrWrData;
      end
    end
  end

  assign msrOut        = msrQ;
  assign srr0Out       = srr0Q;
  assign srr1Out       = srr1Q;
  assign redirectPc    = pcQ;
  assign redirectValid = redirQ;

  assert_entry_ee_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    redirQ |-> !msrQ[BIT_EE]);
  assert_le_tracks_ile_R5: assert property (@(posedge clk) disable iff (!rstN)
    redirQ |-> (msrQ[BIT_LE] == msrQ[BIT_ILE]));
  assert_vec_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    redirQ |-> (pcQ[7:0] == 8'h00));
  assert_save_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    redirQ |-> ((srr1Q & ~(MSR_SAVE_MASK | PROG_FLAG)) == '0));
endmodule

// File: rtl/trap_entry_top.sv
module trap_entry_top
  import trap_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncValid,
  input  logic [2:0]  syncCause,
  input  logic        extIrq,
  input  logic        decEvent,
  input  logic        smiReq,
  input  logic [31:0] curPc,
  input  logic [31:0] nextPc,
  input  logic        msrWrEn,
  input  logic [31:0] msrWrData,
  output logic [31:0] msrOut,
  output logic [31:0] srr0Out,
  output logic [31:0] srr1Out,
  output logic [31:0] redirectPc,
  output logic        redirectValid,
  output logic        fatal
);
  entryStrobe_t strobe;

  trap_entry_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .syncValid(syncValid), .syncCause(syncCause),
    .asyncReq({smiReq, decEvent, extIrq}), .msrEe(msrOut[BIT_EE]),
    .strobe(strobe), .fatal(fatal)
  );

  trap_entry_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc), .nextPc(nextPc),
    .msrWrEn(msrWrEn), .msrWrData(msrWrData), .msrOut(msrOut),
    .srr0Out(srr0Out), .srr1Out(srr1Out), .redirectPc(redirectPc),
    .redirectValid(redirectValid)
  );
endmodule

// File: tb/trap_entry_top_tb_top.sv
module trap_entry_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {msr, cause, curPc, nextPc}
  localparam logic [98:0] VECS [NVEC] = '{
    {32'h0007_FFFF, 3'd2, 32'h0000_1000, 32'h0000_1004},
    {32'h0000_0040, 3'd3, 32'h0000_2000, 32'h0000_2004},
    {32'h0000_FF73, 3'd0, 32'h0000_3000, 32'h0000_3004},
    {32'h0001_0000, 3'd1, 32'h0000_4000, 32'h0000_4004},
    {32'h0000_0001, 3'd2, 32'h0000_5000, 32'h0000_5004},
    {32'hFFFF_FFBF, 3'd3, 32'h0000_6000, 32'h0000_6004}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic syncValid = 1'b0; logic [2:0] syncCause = '0;
  logic extIrq = 1'b0, decEvent = 1'b0, smiReq = 1'b0;
  logic [31:0] curPc = '0, nextPc = '0;
  logic msrWrEn = 1'b0; logic [31:0] msrWrData = '0;
  logic [31:0] msrOut, srr0Out, srr1Out, redirectPc;
  logic redirectValid, fatal;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_top dut_i (.*);

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelMsr(input logic [31:0] m);
    logic [31:0] r;
    r = m & 32'hFFFB_10CD;
    r[0] = m[16];
    return r;
  endfunction

  function automatic logic [31:0] modelVec(input logic [31:0] m, input logic [2:0] c);
    logic [31:0] off;
    off = (c == 0) ? 32'h300 : (c == 1) ? 32'h400 : (c == 2) ? 32'h700 : 32'hC00;
    return (m[6] ? 32'hFFF0_0000 : 32'h0) | off;
  endfunction

  task automatic writeMsr(input logic [31:0] v);
    cyc(); msrWrEn = 1'b1; msrWrData = v;
    cyc(); msrWrEn = 1'b0;
  endtask

  task automatic doReset();
    cyc(); rstN = 1'b0; cyc(); cyc(); rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1", redirectPc, 32'hFFF0_0100);
    chk("R1", msrOut, 32'h40);
    chk("R1", srr0Out, 0);
    chk("R1", srr1Out, 0);
    chk("R1", {31'b0, redirectValid}, 0);
    chk("R1", {31'b0, fatal}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] m, cp, np; logic [2:0] c;
      {m, c, cp, np} = VECS[i];
      writeMsr(m);
      chk("R4", msrOut, m);
      curPc = cp; nextPc = np; syncValid = 1'b1; syncCause = c;
      cyc(); syncValid = 1'b0;
      chk("R11", {31'b0, redirectValid}, 1);
      chk("R2", srr1Out, (m & 32'hFF73) | ((c == 2) ? 32'h20000 : 0));
      chk("R3", srr0Out, (c == 2) ? cp : np);
      chk("R4", msrOut & ~32'h1, modelMsr(m) & ~32'h1);
      chk("R5", {31'b0, msrOut[0]}, {31'b0, m[16]});
      chk("R6", redirectPc, modelVec(m, c));
      cyc();
      chk("R11", {31'b0, redirectValid}, 0);
    end

    // async priority and EE gate
    nextPc = 32'h0000_7004;
    writeMsr(32'h0000_8040);
    extIrq = 1'b1; decEvent = 1'b1;
    cyc(); extIrq = 1'b0; decEvent = 1'b0;
    cyc();
    chk("R8", redirectPc, 32'hFFF0_0500);
    chk("R7", {31'b0, redirectValid}, 1);
    chk("R2", srr1Out, 32'h0000_8040);
    chk("R3", srr0Out, 32'h0000_7004);
    chk("R4", msrOut, 32'h40);
    cyc(); cyc(); cyc();
    chk("R7", {31'b0, redirectValid}, 0);
    chk("R7", redirectPc, 32'hFFF0_0500);
    writeMsr(32'h0000_8000);
    cyc();
    chk("R8", redirectPc, 32'h0000_0900);
    chk("R8", {31'b0, redirectValid}, 1);

    // system management held off by EE, then sync beats it
    smiReq = 1'b1; cyc(); smiReq = 1'b0;
    cyc(); cyc(); cyc();
    chk("R7", redirectPc, 32'h0000_0900);
    chk("R9", {31'b0, redirectValid}, 0);
    cyc(); msrWrEn = 1'b1; msrWrData = 32'h0000_8000;
    cyc(); msrWrEn = 1'b0; syncValid = 1'b1; syncCause = 3'd3;
    cyc(); syncValid = 1'b0;
    chk("R9", redirectPc, 32'h0000_0C00);
    chk("R9", {31'b0, msrOut[15]}, 0);
    writeMsr(32'h0000_8000);
    cyc();
    chk("R8", redirectPc, 32'h0000_1400);
    chk("R2", srr1Out, 32'h0000_8000);
    cyc(); cyc();
    chk("R8", {31'b0, redirectValid}, 0);

    // fatal lock
    syncValid = 1'b1; syncCause = 3'd5;
    cyc(); syncValid = 1'b0;
    chk("R10", {31'b0, fatal}, 1);
    chk("R10", {31'b0, redirectValid}, 0);
    syncValid = 1'b1; syncCause = 3'd2;
    cyc(); syncValid = 1'b0;
    chk("R10", {31'b0, redirectValid}, 0);
    chk("R10", redirectPc, 32'h0000_1400);
    doReset();
    chk("R10", {31'b0, fatal}, 0);
    chk("R1", redirectPc, 32'hFFF0_0100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule